// File: doc/BRIEF.md
# Switch Reset and Boot Configuration Sequencer

This block brings an external Ethernet switch chip out of reset and gives it a working initial setup without software. After a start request it drives the chip's reset pin through three timed phases: high, then low, then high again. While the reset pin is low and during the release phase it holds strap levels on the serial clock, data and select lines. It then lets go of those lines and leaves the reset pin driven high.

Once reset is over, the sequencer makes two register writes through a separate serial write engine, which it reaches with a request pulse, an address and a 16-bit data word. That engine reports back with a busy level and a done pulse. The first write sets up the CPU-facing port: auto crossover, default VLAN 15, tagging, and 100 Mbit/s full duplex with autonegotiation and flow control. The second write turns on VLAN mode and MAC cloning. When the second write is done, a done flag rises and stays high until the next start. The millisecond intervals come from a prescaler on the system clock.

Top module: `sw_boot_seq`

## Requirements
- R1: After reset, every output enable (reset, select, clock, data) is low, the write request is low and the done flag is low.
- R2: After a start request, the reset pin is driven high (enable 1, level 1) for HI_MS milliseconds. One millisecond is CLK_PER_MS clock cycles, and the interval is between HI_MS*CLK_PER_MS and HI_MS*CLK_PER_MS+2 cycles long.
- R3: The reset pin is then driven low for LO_MS milliseconds, within the same two-cycle tolerance.
- R4: Whenever the reset pin is driven low, and throughout the release phase, the clock line is driven to 1 and the data line and select line are driven to 0. All three have their enables at 1.
- R5: The reset pin is then driven high for REL_MS milliseconds of release, within the same two-cycle tolerance, with the straps of R4 still applied.
- R6: After the release phase the reset pin stays driven high, and the select, clock and data enables return to 0 for the rest of the sequence and while done.
- R7: The first write has address 0x08 and data 0xBC1F. Bit 15 is auto crossover, bits 13:10 hold 15 as the default VLAN, bit 4 is tagging, and bits 3:0 are all set. The write request is a one-cycle pulse, raised only in a cycle after one where the write engine's busy level was low.
- R8: The second write has address 0x11 and data 0xFF30. It is requested only after the done pulse of the first write.
- R9: The done flag rises after the done pulse of the second write and stays high until the next accepted start. A start while done restarts the whole sequence.
- R10: A start request while the sequence is running has no effect. The phase lengths stay unchanged and exactly two writes are made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Request to run the boot sequence |
| wrBusy | input | 1 | Serial write engine is busy |
| wrDone | input | 1 | One-cycle pulse when a write has finished |
| rstPinOut | output | 1 | Level for the switch reset pin |
| rstPinOe | output | 1 | Output enable for the reset pin |
| csOut | output | 1 | Level for the serial select line |
| csOe | output | 1 | Output enable for the select line |
| sclkOut | output | 1 | Level for the serial clock line (strap) |
| sclkOe | output | 1 | Output enable for the serial clock line |
| sdatOut | output | 1 | Level for the serial data line (strap) |
| sdatOe | output | 1 | Output enable for the serial data line |
| wrReq | output | 1 | One-cycle write request pulse |
| wrAddr | output | 8 | Register address of the write |
| wrData | output | 16 | Register data of the write |
| seqDone | output | 1 | Sequence finished |

## Verification
The bench builds the block with CLK_PER_MS=10, HI_MS=3, LO_MS=5 and REL_MS=4. With these values all three phases finish in a few hundred cycles. The exact phase lengths can then be counted cycle by cycle, and several complete runs fit in one run of the bench: restart from done, an extra start during the low phase, and a write engine that holds busy before accepting. At the default millisecond scale each run would need millions of cycles.

// File: rtl/sw_boot_pkg.sv
package sw_boot_pkg;
  localparam int MS_W = 16;

  typedef enum logic [2:0] {
    PH_OFF,
    PH_HOLD,
    PH_LOW,
    PH_REL,
    PH_CFG,
    PH_FIN
  } pinPhase_e;

  typedef struct packed {
    logic            loadTimer;
    logic [MS_W-1:0] loadMs;
    pinPhase_e       phase;
    logic            issueWr;
    logic            wrSel;
  } ctrlCmd_t;

  // CPU port word: auto crossover, default VLAN, tagging, speed/duplex/aneg/flow
  function automatic logic [15:0] cpuPortWord(input logic [3:0] pvid);
    return 16'h8000 | (16'(pvid) << 10) | 16'h0010 | 16'h000F;
  endfunction
endpackage

// File: rtl/sw_boot_ctrl.sv
module sw_boot_ctrl
  import sw_boot_pkg::*;
#(
  parameter int HI_MS  = 20,
  parameter int LO_MS  = 100,
  parameter int REL_MS = 30
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     startReq,
  input  logic     wrBusy,
  input  logic     wrDone,
  input  logic     timerDone,
  output ctrlCmd_t cmd
);
  typedef enum logic [3:0] {
    S_IDLE, S_HOLD, S_LOW, S_REL, S_WR0, S_WAIT0, S_WR1, S_WAIT1, S_FIN
  } state_e;

  localparam logic [MS_W-1:0] HI_LEN  = MS_W'(HI_MS);
  localparam logic [MS_W-1:0] LO_LEN  = MS_W'(LO_MS);
  localparam logic [MS_W-1:0] REL_LEN = MS_W'(REL_MS);

  state_e state, stateNxt;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt      = state;
    cmd.loadTimer = 1'b0;
    cmd.loadMs    = '0;
    cmd.issueWr   = 1'b0;
    cmd.wrSel     = 1'b0;
    unique case (state)
      S_IDLE, S_FIN: if (startReq) begin
        stateNxt      = S_HOLD;
        cmd.loadTimer = 1'b1;
        cmd.loadMs    = HI_LEN;
      end
      S_HOLD: if (timerDone) begin
        stateNxt      = S_LOW;
        cmd.loadTimer = 1'b1;
        cmd.loadMs    = LO_LEN;
      end
      S_LOW: if (timerDone) begin
        stateNxt      = S_REL;
        cmd.loadTimer = 1'b1;
        cmd.loadMs    = REL_LEN;
      end
      S_REL: if (timerDone) stateNxt = S_WR0;
      S_WR0: if (!wrBusy) begin
        stateNxt    = S_WAIT0;
        cmd.issueWr = 1'b1;
        cmd.wrSel   = 1'b0;
      end
      S_WAIT0: if (wrDone) stateNxt = S_WR1;
      S_WR1: if (!wrBusy) begin
        stateNxt    = S_WAIT1;
        cmd.issueWr = 1'b1;
        cmd.wrSel   = 1'b1;
      end
      S_WAIT1: if (wrDone) stateNxt = S_FIN;
      default: stateNxt = S_IDLE;
    endcase
  end

  always_comb begin
    unique case (state)
      S_HOLD:                         cmd.phase = PH_HOLD;
      S_LOW:                          cmd.phase = PH_LOW;
      S_REL:                          cmd.phase = PH_REL;
      S_WR0, S_WAIT0, S_WR1, S_WAIT1: cmd.phase = PH_CFG;
      S_FIN:                          cmd.phase = PH_FIN;
      default:                        cmd.phase = PH_OFF;
    endcase
  end
endmodule

// File: rtl/sw_boot_dp.sv
module sw_boot_dp
  import sw_boot_pkg::*;
#(
  parameter int          CLK_PER_MS = 125000,
  parameter int          ADDR_W     = 8,
  parameter int          DATA_W     = 16,
  parameter logic [ADDR_W-1:0] ADDR0 = 8'h08,
  parameter logic [DATA_W-1:0] DATA0 = 16'hBC1F,
  parameter logic [ADDR_W-1:0] ADDR1 = 8'h11,
  parameter logic [DATA_W-1:0] DATA1 = 16'hFF30
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlCmd_t          cmd,
  output logic              timerDone,
  output logic              rstPinOut,
  output logic              rstPinOe,
  output logic              csOut,
  output logic              csOe,
  output logic              sclkOut,
  output logic              sclkOe,
  output logic              sdatOut,
  output logic              sdatOe,
  output logic              wrReq,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic              seqDone
);
  localparam int PRE_W = (CLK_PER_MS > 1) ? $clog2(CLK_PER_MS) : 1;

  logic [MS_W-1:0] msLeft;
  logic            msTick;

  generate
    if (CLK_PER_MS > 1) begin : g_pre
      localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLK_PER_MS - 1);
      logic [PRE_W-1:0] preCnt;
      always_ff @(posedge clk) begin
        if (!rstN || cmd.loadTimer) preCnt <= '0;
        else if (preCnt == PRE_LAST) preCnt <= '0;
        else                         preCnt <= preCnt + 1'b1;
      end
      assign msTick = (preCnt == PRE_LAST) && !cmd.loadTimer;
    end else begin : g_nopre
      assign msTick = !cmd.loadTimer;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN)                          msLeft <= '0;
    else if (cmd.loadTimer)             msLeft <= cmd.loadMs;
    else if (msTick && msLeft != '0)    msLeft <= msLeft - 1'b1;
  end

  assign timerDone = (msLeft == '0);

  // Pin levels follow the phase with one register stage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rstPinOut <= 1'b0; rstPinOe <= 1'b0;
      csOut     <= 1'b0; csOe     <= 1'b0;
      sclkOut   <= 1'b0; sclkOe   <= 1'b0;
      sdatOut   <= 1'b0; sdatOe   <= 1'b0;
      seqDone   <= 1'b0;
    end else begin
      rstPinOe  <= (cmd.phase != PH_OFF);
      rstPinOut <= (cmd.phase != PH_OFF) && (cmd.phase != PH_LOW);
      csOut     <= 1'b0;
      sdatOut   <= 1'b0;
      csOe      <= (cmd.phase == PH_LOW) || (cmd.phase == PH_REL);
      sclkOe    <= (cmd.phase == PH_LOW) || (cmd.phase == PH_REL);
      sdatOe    <= (cmd.phase == PH_LOW) || (cmd.phase == PH_REL);
      sclkOut   <= (cmd.phase == PH_LOW) || (cmd.phase == PH_REL);
      seqDone   <= (cmd.phase == PH_FIN);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrReq  <= 1'b0;
      wrAddr <= '0;
      wrData <= '0;
    end else begin
      wrReq <= cmd.issueWr;
      if (cmd.issueWr) begin
        wrAddr <= cmd.wrSel ? ADDR1 : ADDR0;
        wrData <= cmd.wrSel ? DATA1 : DATA0;
      end
    end
  end
endmodule

// File: rtl/sw_boot_seq.sv
module sw_boot_seq
  import sw_boot_pkg::*;
#(
  parameter int CLK_PER_MS = 125000,
  parameter int HI_MS      = 20,
  parameter int LO_MS      = 100,
  parameter int REL_MS     = 30,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 16,
  parameter logic [3:0] CPU_PVID = 4'hF,
  parameter logic [ADDR_W-1:0] CPU_ADDR  = 8'h08,
  parameter logic [ADDR_W-1:0] MODE_ADDR = 8'h11,
  parameter logic [DATA_W-1:0] MODE_DATA = 16'hFF30
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic              wrBusy,
  input  logic              wrDone,
  output logic              rstPinOut,
  output logic              rstPinOe,
  output logic              csOut,
  output logic              csOe,
  output logic              sclkOut,
  output logic              sclkOe,
  output logic              sdatOut,
  output logic              sdatOe,
  output logic              wrReq,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic              seqDone
);
  localparam logic [DATA_W-1:0] CPU_DATA = DATA_W'(cpuPortWord(CPU_PVID));

  ctrlCmd_t cmd;
  logic     timerDone;

  sw_boot_ctrl #(.HI_MS(HI_MS), .LO_MS(LO_MS), .REL_MS(REL_MS)) u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .wrBusy(wrBusy),
    .wrDone(wrDone), .timerDone(timerDone), .cmd(cmd)
  );

  sw_boot_dp #(
    .CLK_PER_MS(CLK_PER_MS), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .ADDR0(CPU_ADDR), .DATA0(CPU_DATA), .ADDR1(MODE_ADDR), .DATA1(MODE_DATA)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .timerDone(timerDone),
    .rstPinOut(rstPinOut), .rstPinOe(rstPinOe), .csOut(csOut), .csOe(csOe),
    .sclkOut(sclkOut), .sclkOe(sclkOe), .sdatOut(sdatOut), .sdatOe(sdatOe),
    .wrReq(wrReq), .wrAddr(wrAddr), .wrData(wrData), .seqDone(seqDone)
  );
endmodule

// File: rtl/sw_boot_chk.sv
module sw_boot_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrBusy,
  input logic              rstPinOut,
  input logic              rstPinOe,
  input logic              csOut,
  input logic              csOe,
  input logic              sclkOut,
  input logic              sclkOe,
  input logic              sdatOut,
  input logic              sdatOe,
  input logic              wrReq,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [DATA_W-1:0] wrData,
  input logic              seqDone
);
  // R4
  strap_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rstPinOe && !rstPinOut) |-> (sclkOe && sclkOut && sdatOe && !sdatOut && csOe && !csOut));

  // R4
  strap_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    sclkOe |-> (sclkOut && sdatOe && !sdatOut && rstPinOe));

  // R6
  done_pins_chk: assert property (@(posedge clk) disable iff (!rstN)
    seqDone |-> (rstPinOe && rstPinOut && !sclkOe && !sdatOe && !csOe));

  // R6
  write_pins_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrReq |-> (rstPinOe && rstPinOut && !sclkOe && !sdatOe && !csOe));

  // R7
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrReq |=> !wrReq);

  // R7
  req_not_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wrReq) |-> !$past(wrBusy));

  // R8
  req_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrReq |-> ((wrAddr == 8'h08 && wrData == 16'hBC1F) ||
               (wrAddr == 8'h11 && wrData == 16'hFF30)));
endmodule

bind sw_boot_seq sw_boot_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrBusy(wrBusy),
  .rstPinOut(rstPinOut), .rstPinOe(rstPinOe), .csOut(csOut), .csOe(csOe),
  .sclkOut(sclkOut), .sclkOe(sclkOe), .sdatOut(sdatOut), .sdatOe(sdatOe),
  .wrReq(wrReq), .wrAddr(wrAddr), .wrData(wrData), .seqDone(seqDone)
);

// File: tb/sw_boot_seq_tb.sv
module sw_boot_seq_tb;
  localparam int CPM = 10;
  localparam int HI  = 3;
  localparam int LO  = 5;
  localparam int REL = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic wrBusy = 1'b0;
  logic wrDone = 1'b0;
  logic rstPinOut, rstPinOe, csOut, csOe, sclkOut, sclkOe, sdatOut, sdatOe;
  logic wrReq, seqDone;
  logic [7:0]  wrAddr;
  logic [15:0] wrData;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  sw_boot_seq #(.CLK_PER_MS(CPM), .HI_MS(HI), .LO_MS(LO), .REL_MS(REL)) u_dut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .wrBusy(wrBusy), .wrDone(wrDone),
    .rstPinOut(rstPinOut), .rstPinOe(rstPinOe), .csOut(csOut), .csOe(csOe),
    .sclkOut(sclkOut), .sclkOe(sclkOe), .sdatOut(sdatOut), .sdatOe(sdatOe),
    .wrReq(wrReq), .wrAddr(wrAddr), .wrData(wrData), .seqDone(seqDone)
  );

  // Monitor state (sampled at negedge)
  int hiCnt, loCnt, relCnt, strapBad, pinsBad, reqBusy, reqCnt, doneCnt;
  int preBusy;
  logic seenLow;
  logic [7:0]  addrLog [2];
  logic [15:0] dataLog [2];
  int doneBeforeReq [2];
  int busyLeft = 0;

  task automatic clearMon();
    hiCnt = 0; loCnt = 0; relCnt = 0; strapBad = 0; pinsBad = 0;
    reqBusy = 0; reqCnt = 0; doneCnt = 0; seenLow = 1'b0;
    for (int i = 0; i < 2; i++) begin
      addrLog[i] = '0; dataLog[i] = '0; doneBeforeReq[i] = -1;
    end
  endtask

  // Write engine model and monitor, both away from the active edge
  always @(negedge clk) begin
    if (rstPinOe && rstPinOut && !sclkOe && !seenLow && !seqDone && reqCnt == 0) hiCnt++;
    if (rstPinOe && !rstPinOut) begin
      loCnt++; seenLow = 1'b1;
      if (!(sclkOe && sclkOut && sdatOe && !sdatOut && csOe && !csOut)) strapBad++;
    end
    if (rstPinOe && rstPinOut && sclkOe) begin
      relCnt++;
      if (!(sclkOut && sdatOe && !sdatOut && csOe && !csOut)) strapBad++;
    end
    if ((wrReq || seqDone) && (sclkOe || sdatOe || csOe || !rstPinOe || !rstPinOut)) pinsBad++;
    wrDone = 1'b0;
    if (wrReq) begin
      if (wrBusy) reqBusy++;
      if (reqCnt < 2) begin
        addrLog[reqCnt] = wrAddr; dataLog[reqCnt] = wrData;
        doneBeforeReq[reqCnt] = doneCnt;
      end
      reqCnt++;
      busyLeft = 3; wrBusy = 1'b1;
    end else if (busyLeft > 0) begin
      busyLeft--;
      if (busyLeft == 0) begin
        wrBusy = 1'b0; wrDone = 1'b1; doneCnt++;
      end
    end else if (preBusy > 0) begin
      preBusy--; wrBusy = (preBusy > 0);
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic pulseStart();
    @(negedge clk); startReq = 1'b1;
    @(negedge clk); startReq = 1'b0;
  endtask

  task automatic waitDone(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (seqDone) begin ok = 1'b1; break; end
    end
  endtask

  task automatic checkRun(input string tag);
    check(hiCnt >= HI*CPM && hiCnt <= HI*CPM+2, "R2", hiCnt, HI*CPM);
    check(loCnt >= LO*CPM && loCnt <= LO*CPM+2, "R3", loCnt, LO*CPM);
    check(strapBad == 0, "R4", strapBad, 0);
    check(relCnt >= REL*CPM && relCnt <= REL*CPM+2, "R5", relCnt, REL*CPM);
    check(pinsBad == 0, "R6", pinsBad, 0);
    check(addrLog[0] == 8'h08 && dataLog[0] == 16'hBC1F, "R7",
          {addrLog[0], dataLog[0]}, {8'h08, 16'hBC1F});
    check(reqBusy == 0, "R7", reqBusy, 0);
    check(addrLog[1] == 8'h11 && dataLog[1] == 16'hFF30, "R8",
          {addrLog[1], dataLog[1]}, {8'h11, 16'hFF30});
    check(doneBeforeReq[1] == 1, "R8", doneBeforeReq[1], 1);
    check(reqCnt == 2, tag, reqCnt, 2);
  endtask

  task automatic t_reset();
    // R1
    check(!rstPinOe && !csOe && !sclkOe && !sdatOe, "R1",
          {rstPinOe, csOe, sclkOe, sdatOe}, 0);
    check(!wrReq && !seqDone, "R1", {wrReq, seqDone}, 0);
  endtask

  task automatic t_basic();
    bit ok;
    clearMon(); preBusy = 0;
    pulseStart();
    waitDone(ok);
    check(ok, "R9", ok, 1);
    checkRun("R9");
    repeat (20) @(negedge clk);
    check(seqDone == 1'b1 && doneCnt == 2, "R9", {seqDone, 8'(doneCnt)}, 2);
  endtask

  task automatic t_busyEngine();
    bit ok;
    // restart from done with a write engine busy before the first write (R7, R9)
    clearMon(); preBusy = 300; wrBusy = 1'b1;
    pulseStart();
    @(negedge clk);
    check(!seqDone && rstPinOe && rstPinOut, "R9", {seqDone, rstPinOut}, 1);
    waitDone(ok);
    check(ok, "R7", ok, 1);
    checkRun("R7");
  endtask

  task automatic t_ignoreStart();
    bit ok;
    // R10: a second start in the low phase leaves timing and writes unchanged
    clearMon(); preBusy = 0; wrBusy = 1'b0;
    pulseStart();
    repeat (HI*CPM + 20) @(negedge clk);
    startReq = 1'b1; @(negedge clk); startReq = 1'b0;
    waitDone(ok);
    check(ok, "R10", ok, 1);
    checkRun("R10");
    repeat (30) @(negedge clk);
    check(reqCnt == 2 && seqDone, "R10", reqCnt, 2);
  endtask

  initial begin
    preBusy = 0;
    clearMon();
    repeat (4) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_basic();
    t_busyEngine();
    t_ignoreStart();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule